// File: doc/BRIEF.md
# Command Control-Area Sequencer

This block holds the control registers of a buffer-based command interface. Host software places a command in a shared word buffer, asks the device to move between idle and ready, starts execution, may cancel the run, and polls for completion. Software sets request bits. The device clears each bit once it has made the requested transition, so a bit that stays set means the request is still pending.

A stub executor sees a start level and a cancel level and returns a one-cycle done pulse. The device acknowledges a request only outside the executing state. A request made during a run therefore waits until the run completes. If any request stays pending for a parameterised number of cycles, a sticky fatal-error flag is set. The default is 200 ms at a 100 MHz clock.

The register port is a plain single-cycle bus with no back-pressure. Every read or write is accepted in the cycle it is presented. Read data and its valid flag appear one cycle later.

Top module: `cmdarea_ctrl`

## Requirements
- R1: After reset the status word reads 0x2 (idle flag set, fatal clear). The request, cancel and start words read 0, and both executor outputs are low.
- R2: Writing bit 0 (ready request) of the request word at offset 0x000 moves the device to the ready state. The device then clears the bit, and the status idle flag (bit 1 of the word at 0x004) reads 0.
- R3: Writing bit 1 (idle request) of the request word moves the device to the idle state. The device then clears the bit, and the status idle flag reads 1.
- R4: Writing 0 to a request bit has no effect. If both request bits are written together, the idle request is served first and the device ends in the ready state with both bits clear.
- R5: Writing exactly 0x00000001 to the start word at 0x00C while the device is ready enters execution. The start word then reads 1 and exec_start is high.
- R6: A start write is ignored when the device is not ready or when the value is anything other than 0x00000001.
- R7: An exec_done pulse during execution ends it. The start word then reads 0, exec_start falls, and the device is neither idle nor ready. An exec_done pulse outside execution is ignored.
- R8: Writing 0x00000001 to the cancel word at 0x008 sets it and writing 0 clears it. Any other value is ignored. exec_cancel is high only while executing with the cancel word set.
- R9: A request written during execution stays pending (its bit reads 1) and is served after completion.
- R10: A request that stays pending for TIMEOUT_CYC cycles sets the fatal flag (status bit 0), which stays set until reset.
- R11: Aligned addresses from 0x080 up to 0xFFC reach a 3968-byte word buffer that can be read and written. Unmapped or misaligned addresses read 0 and ignore writes.
- R12: bus_rvalid is high exactly in the cycle after a read is presented, and it carries that read's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| exec_start | output | 1 | Executor run level |
| exec_cancel | output | 1 | Executor cancel level |
| exec_done | input | 1 | Executor completion pulse |

## Verification
The assertions check the following on every cycle:
- execution begins only from the ready state;
- a completion pulse ends execution;
- a run holds until done arrives;
- cancel never shows outside a run;
- pending requests are served in the right direction outside a run;
- the fatal flag never falls;
- read valid tracks read strobes.

Only the bench scenarios can show the rest:
- that the register words read back the values software expects;
- that full-word start and cancel values other than 1 are ignored;
- that both request bits written together end in ready;
- that a stalled run trips the timeout;
- that buffer contents survive arbitrary traffic.

// File: rtl/cmdarea_pkg.sv
package cmdarea_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_EXEC  = 2'd2,
    ST_DONE  = 2'd3
  } ca_state_e;

  localparam int REQ_RDY_BIT  = 0;
  localparam int REQ_IDLE_BIT = 1;

  localparam int OFS_REQ    = 'h000;
  localparam int OFS_STS    = 'h004;
  localparam int OFS_CANCEL = 'h008;
  localparam int OFS_START  = 'h00C;
endpackage

// File: rtl/cmdarea_fsm.sv
module cmdarea_fsm
  import cmdarea_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] req_set,
  input  logic      start_wr1,
  input  logic      cancel_wr1,
  input  logic      cancel_wr0,
  input  logic      exec_done,
  output ca_state_e state_q,
  output logic [1:0] req_q,
  output logic      cancel_q
);
  ca_state_e  state_d;
  logic [1:0] req_clr;

  // Requests are served one per cycle, idle first, never during a run.
  always_comb begin
    state_d = state_q;
    req_clr = '0;
    if (state_q == ST_EXEC) begin
      if (exec_done) state_d = ST_DONE;
    end else if (req_q[REQ_IDLE_BIT]) begin
      state_d = ST_IDLE;
      req_clr[REQ_IDLE_BIT] = 1'b1;
    end else if (req_q[REQ_RDY_BIT]) begin
      state_d = ST_READY;
      req_clr[REQ_RDY_BIT] = 1'b1;
    end else if (state_q == ST_READY && start_wr1) begin
      state_d = ST_EXEC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      req_q    <= '0;
      cancel_q <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= (req_q & ~req_clr) | req_set;
      if (cancel_wr1)      cancel_q <= 1'b1;
      else if (cancel_wr0) cancel_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdarea_timer.sv
module cmdarea_timer #(
  parameter int TIMEOUT_CYC = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  output logic fatal_q
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fatal_q <= 1'b0;
    end else begin
      if (!pending)            cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LIMIT)      fatal_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cmdarea_buf.sv
module cmdarea_buf #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 992,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) rdata <= mem[idx];
  end
endmodule

// File: rtl/cmdarea_ctrl.sv
module cmdarea_ctrl
  import cmdarea_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int BUF_BASE    = 'h80,
  parameter int BUF_BYTES   = 'hF80,
  parameter int TIMEOUT_CYC = 20_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              exec_start,
  output logic              exec_cancel,
  input  logic              exec_done
);
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int IDX_W     = $clog2(BUF_WORDS);
  localparam int OFF_W     = ADDR_W + 1;

  ca_state_e         state_q;
  logic [1:0]        req_q;
  logic              cancel_q;
  logic              fatal_q;
  logic [OFF_W-1:0]  buf_off;
  logic              in_buf;
  logic              hit_req, hit_start, hit_cancel;
  logic [1:0]        req_set;
  logic              start_wr1, cancel_wr1, cancel_wr0;
  logic [DATA_W-1:0] reg_val;
  logic [DATA_W-1:0] reg_rd_q;
  logic [DATA_W-1:0] buf_rdata;
  logic              sel_buf_q;

  // Address decode
  assign buf_off = {1'b0, bus_addr} - OFF_W'(BUF_BASE);
  assign in_buf  = ({1'b0, bus_addr} >= OFF_W'(BUF_BASE)) &&
                   (buf_off < OFF_W'(BUF_BYTES)) && (buf_off[1:0] == 2'b00);

  assign hit_req    = bus_addr == ADDR_W'(OFS_REQ);
  assign hit_start  = bus_addr == ADDR_W'(OFS_START);
  assign hit_cancel = bus_addr == ADDR_W'(OFS_CANCEL);

  assign req_set    = (bus_wr && hit_req) ? bus_wdata[1:0] : 2'b00;
  assign start_wr1  = bus_wr && hit_start  && (bus_wdata == DATA_W'(1));
  assign cancel_wr1 = bus_wr && hit_cancel && (bus_wdata == DATA_W'(1));
  assign cancel_wr0 = bus_wr && hit_cancel && (bus_wdata == '0);

  cmdarea_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_set    (req_set),
    .start_wr1  (start_wr1),
    .cancel_wr1 (cancel_wr1),
    .cancel_wr0 (cancel_wr0),
    .exec_done  (exec_done),
    .state_q    (state_q),
    .req_q      (req_q),
    .cancel_q   (cancel_q)
  );

  cmdarea_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (|req_q),
    .fatal_q (fatal_q)
  );

  cmdarea_buf #(.DATA_W(DATA_W), .WORDS(BUF_WORDS)) buf_i (
    .clk   (clk),
    .wr_en (bus_wr && in_buf),
    .rd_en (bus_rd && in_buf),
    .idx   (buf_off[IDX_W+1:2]),
    .wdata (bus_wdata),
    .rdata (buf_rdata)
  );

  // Register read mux
  always_comb begin
    reg_val = '0;
    case (bus_addr)
      ADDR_W'(OFS_REQ):    reg_val = {{(DATA_W-2){1'b0}}, req_q};
      ADDR_W'(OFS_STS):    reg_val = {{(DATA_W-2){1'b0}}, state_q == ST_IDLE, fatal_q};
      ADDR_W'(OFS_CANCEL): reg_val = {{(DATA_W-1){1'b0}}, cancel_q};
      ADDR_W'(OFS_START):  reg_val = {{(DATA_W-1){1'b0}}, state_q == ST_EXEC};
      default:             reg_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      sel_buf_q  <= 1'b0;
      reg_rd_q   <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        sel_buf_q <= in_buf;
        reg_rd_q  <= reg_val;
      end
    end
  end

  assign bus_rdata   = sel_buf_q ? buf_rdata : reg_rd_q;
  assign exec_start  = state_q == ST_EXEC;
  assign exec_cancel = exec_start && cancel_q;
endmodule

// File: rtl/cmdarea_chk.sv
module cmdarea_chk
  import cmdarea_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rd,
  input logic       bus_rvalid,
  input logic       exec_start,
  input logic       exec_cancel,
  input logic       exec_done,
  input ca_state_e  state_q,
  input logic [1:0] req_q,
  input logic       fatal
);
  p_ready_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_EXEC && req_q == 2'b01) |=> state_q == ST_READY);

  p_idle_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_EXEC && req_q[1]) |=> state_q == ST_IDLE);

  p_start_from_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_start) |-> $past(state_q) == ST_READY);

  p_done_ends_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_start && exec_done) |=> !exec_start);

  p_cancel_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_cancel |-> exec_start);

  p_run_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && !exec_done) |=> state_q == ST_EXEC);

  p_fatal_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);

  p_rvalid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_rvalid_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

bind cmdarea_ctrl cmdarea_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rd      (bus_rd),
  .bus_rvalid  (bus_rvalid),
  .exec_start  (exec_start),
  .exec_cancel (exec_cancel),
  .exec_done   (exec_done),
  .state_q     (state_q),
  .req_q       (req_q),
  .fatal       (fatal_q)
);

// File: tb/cmdarea_ctrl_tb_top.sv
module cmdarea_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 40;
  localparam int M_IDLE = 0, M_READY = 1, M_EXEC = 2, M_DONE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, exec_start, exec_cancel;
  logic        exec_done = 1'b0;

  int n_chk = 0, n_fail = 0;
  int m_state = M_IDLE;
  logic [1:0] m_pend = '0;
  logic m_cancel = 1'b0, m_fatal = 1'b0;
  logic [31:0] sh_buf [16];
  logic        sh_ok  [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdarea_ctrl #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .exec_start(exec_start),
    .exec_cancel(exec_cancel), .exec_done(exec_done)
  );

  // Reference model
  function automatic void m_ack();
    if (m_state != M_EXEC) begin
      if (m_pend[1]) m_state = M_IDLE;
      if (m_pend[0]) m_state = M_READY;
      m_pend = 2'b00;
    end
  endfunction
  function automatic void m_req(logic [1:0] b);
    m_pend = m_pend | b;
    m_ack();
  endfunction
  function automatic void m_start(logic [31:0] v);
    if (v == 32'd1 && m_state == M_READY && m_pend == 2'b00) m_state = M_EXEC;
  endfunction
  function automatic void m_done();
    if (m_state == M_EXEC) m_state = M_DONE;
    m_ack();
  endfunction
  function automatic void m_cxl(logic [31:0] v);
    if (v == 32'd1) m_cancel = 1'b1;
    else if (v == 32'd0) m_cancel = 1'b0;
  endfunction
  function automatic logic [31:0] exp_sts();
    return {30'd0, m_state == M_IDLE, m_fatal};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R12 rvalid", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    bus_read(12'h004, d); check({tag, " status"}, d, exp_sts());
    bus_read(12'h00C, d); check({tag, " start"},  d, {31'd0, m_state == M_EXEC});
    bus_read(12'h008, d); check({tag, " cancel"}, d, {31'd0, m_cancel});
    bus_read(12'h000, d); check({tag, " request"}, d, {30'd0, m_pend});
    check({tag, " exec_start"},  {31'd0, exec_start},  {31'd0, m_state == M_EXEC});
    check({tag, " exec_cancel"}, {31'd0, exec_cancel}, {31'd0, m_state == M_EXEC && m_cancel});
  endtask

  task automatic do_req(logic [1:0] b);  bus_write(12'h000, {30'd0, b}); m_req(b); settle(); endtask
  task automatic do_start(logic [31:0] v); bus_write(12'h00C, v); m_start(v); settle(); endtask
  task automatic do_cxl(logic [31:0] v); bus_write(12'h008, v); m_cxl(v); settle(); endtask
  task automatic do_done(); pulse_done(); m_done(); settle(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) sh_ok[i] = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R12 rvalid idle", {31'd0, bus_rvalid}, 32'd0);
    check_all("R1");
    // R6 start while idle ignored
    do_start(32'd1);  check_all("R6 idle start");
    // R2 ready request
    do_req(2'b01);    check_all("R2");
    // R6 wrong value, R5 proper start
    do_start(32'd2);  check_all("R6 value");
    do_start(32'h101); check_all("R6 value2");
    do_start(32'd1);  check_all("R5");
    // R8 cancel handling
    do_cxl(32'd1);    check_all("R8 set");
    do_cxl(32'd3);    check_all("R8 ignore");
    // R7 completion, extra done ignored
    do_done();        check_all("R7");
    do_done();        check_all("R7 stray");
    do_cxl(32'd0);    check_all("R8 clear");
    // R3 idle request
    do_req(2'b10);    check_all("R3");
    // R4 zero write, then both bits
    do_req(2'b00);    check_all("R4 zero");
    do_req(2'b11);    check_all("R4 both");
    // R9 request during run
    do_start(32'd1);
    do_req(2'b10);    check_all("R9 pending");
    do_done();        check_all("R9 served");

    // R11 buffer edges and unmapped space
    bus_write(12'h080, 32'hA5A5_0001);
    bus_write(12'hFFC, 32'h5A5A_0FFC);
    bus_write(12'h081, 32'hDEAD_BEEF);
    bus_read(12'h080, d); check("R11 first", d, 32'hA5A5_0001);
    bus_read(12'hFFC, d); check("R11 last",  d, 32'h5A5A_0FFC);
    bus_read(12'h081, d); check("R11 misaligned", d, 32'd0);
    bus_read(12'h010, d); check("R11 unmapped", d, 32'd0);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: if (m_state == M_EXEC) do_done();
           else do_req(2'($urandom_range(0, 3)));
        1: do_start(($urandom_range(0, 1) == 0) ? 32'd1 : $urandom());
        2: do_cxl(($urandom_range(0, 2) == 0) ? $urandom() : 32'($urandom_range(0, 1)));
        3: do_done();
        default: begin
          int k;
          k = int'($urandom_range(0, 15));
          if ($urandom_range(0, 1) == 0) begin
            sh_buf[k] = $urandom(); sh_ok[k] = 1'b1;
            bus_write(12'(32'h80 + 4 * 61 * k), sh_buf[k]);
          end else if (sh_ok[k]) begin
            bus_read(12'(32'h80 + 4 * 61 * k), d);
            check("R11 random", d, sh_buf[k]);
          end
        end
      endcase
      check_all("random R2/R5/R7");
    end

    // R10 timeout on a stalled run
    if (m_state == M_EXEC) do_done();
    do_req(2'b01);
    do_start(32'd1);
    bus_write(12'h000, 32'd2); m_pend = 2'b10;
    repeat (TMO / 2) @(negedge clk);
    bus_read(12'h004, d); check("R10 early", d, exp_sts());
    repeat (TMO + 10) @(negedge clk);
    m_fatal = 1'b1;
    bus_read(12'h004, d); check("R10 fatal", d, exp_sts());
    do_done();
    check_all("R10 sticky");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule